// File: doc/BRIEF.md
# Modem Handshake Control and Status

This block is the modem-line part of a 16550-style serial port. A CPU writes an 8-bit control register that drives the two active-low outgoing handshake pins, DTR and RTS, and holds an interrupt enable bit. The CPU reads a status byte. Its upper nibble gives the asserted state of the four incoming lines: carrier detect, ring, data-set-ready and clear-to-send. Its lower nibble holds sticky change flags that clear when the CPU reads the status byte. The incoming pins are asynchronous, so they pass through a synchronizer before the block uses them.

Setting a loopback bit puts the block into a self-test mode. In this mode the external inputs are ignored, the outgoing pins are parked inactive, and four control bits stand in for the four incoming lines. The CPU can then exercise the whole status and interrupt path without a cable. Whenever a change flag is set and the enable bit is on, the block raises a modem-status interrupt request for the port's interrupt logic.

Top module: `modem_handshake`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0x00, dtr_n and rts_n are 1, and irq_gate and msi_req are 0.
- R2: With loopback off, dtr_n is the inverse of control bit 0 and rts_n is the inverse of control bit 1. The control byte reads back as written.
- R3: Status bits 7, 6, 5 and 4 read 1 while dcd_n, ri_n, dsr_n and cts_n are low, respectively. A pin change appears in these bits two clocks after the pin changes.
- R4: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) set one clock after the matching level bit changes in either direction.
- R5: Status bit 2 sets only when ri_n goes from low to high, which is the ring ending. ri_n going from high to low sets no flag.
- R6: Once set, a change flag stays set until the CPU reads the status byte.
- R7: A status read (reg_rd=1, reg_sel=1) returns the current byte and clears bits 3..0 at the end of that cycle. A change that is detected during the read cycle is kept and shows on the next read.
- R8: Control bit 4 selects loopback. In loopback the external pins are ignored. DSR follows control bit 0, CTS follows bit 1, RI follows bit 2 and DCD follows bit 3, and the change flags follow these internal lines under the rules of R4 and R5.
- R9: In loopback, dtr_n and rts_n are held at 1 whatever control bits 0 and 1 hold.
- R10: irq_gate equals control bit 3 outside loopback and is 0 in loopback.
- R11: msi_req is 1 when control bit 3 is 1 and any of status bits 3..0 is set. It falls in the clock after a status read that clears the flags.
- R12: Writes with reg_sel=1 are ignored. The status byte is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a status read clears the change flags |
| reg_sel | input | 1 | Register select: 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_gate | output | 1 | Enables the port's interrupt output |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The bench drives a pin change so that it reaches the edge detector in the same cycle as a status read. A design that clears after merging the new change would lose that event for good. It moves the ring line both ways and expects a flag only when the ring ends; a design using a plain toggle detector, or the wrong polarity, flags the start of the ring as well. In loopback it pulls every external pin active and expects the status byte to follow only the control bits, which catches a design with the cross-wiring swapped or inputs not isolated. Leaving loopback with different line states checks that the changes seen at the switch-over are flagged.

// File: rtl/modem_handshake.sv
module modem_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       irq_gate,
  output logic       msi_req
);

  localparam int LAST = SYNC_STAGES - 1;

  // line order in every 4-bit vector: {dcd, ri, dsr, cts}
  logic [3:0] sync_q [SYNC_STAGES];
  logic [7:0] ctl_q;
  logic [3:0] lvl, lvl_q, flags_q, evt;
  logic       loop, stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 4'hF;
    end else begin
      sync_q[0] <= {dcd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign loop    = ctl_q[4];
  assign stat_rd = reg_rd & reg_sel;
  assign lvl     = loop ? {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]} : ~sync_q[LAST];
  assign evt     = {lvl[3] ^ lvl_q[3], lvl_q[2] & ~lvl[2], lvl[1] ^ lvl_q[1], lvl[0] ^ lvl_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      lvl_q   <= '0;
      flags_q <= '0;
    end else begin
      if (reg_wr && !reg_sel) ctl_q <= reg_wdata;
      lvl_q   <= lvl;
      flags_q <= (stat_rd ? 4'h0 : flags_q) | evt;
    end
  end

  assign reg_rdata = reg_sel ? {lvl, flags_q} : ctl_q;
  assign dtr_n     = ~(ctl_q[0] & ~loop);
  assign rts_n     = ~(ctl_q[1] & ~loop);
  assign irq_gate  = ctl_q[3] & ~loop;
  assign msi_req   = ctl_q[3] & (|flags_q);

  p_dtr_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !reg_wdata[4]) |=> (dtr_n == !$past(reg_wdata[0])));

  p_loop_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[4]) |=> (dtr_n && rts_n));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (($past(flags_q) & ~flags_q) == 4'h0));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == 4'h0) |=> (flags_q == 4'h0));

  p_ring_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[2]) |-> ($past(lvl_q[2]) && !lvl_q[2]));

  p_msi_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == 4'h0) |=> !msi_req);

endmodule

// File: tb/modem_handshake_test.sv
module modem_handshake_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic dtr_n, rts_n, irq_gate, msi_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_handshake uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cts_n(cts_n), .dsr_n(dsr_n),
    .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n),
    .irq_gate(irq_gate), .msi_req(msi_req));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 0; reg_sel = 0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d);
    reg_rd = 1; reg_sel = sel; #1;
    d = reg_rdata;
    tick();
    reg_rd = 0; reg_sel = 0;
  endtask

  task automatic peek(output logic [7:0] d);
    reg_sel = 1; #1; d = reg_rdata; reg_sel = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'd1);
    chk("R1 rts_n", {7'd0, rts_n}, 8'd1);
    chk("R1 irq", {6'd0, irq_gate, msi_req}, 8'd0);
    rd(0, d); chk("R1 ctl", d, 8'h00);
    rd(1, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_control;
    logic [7:0] d;
    wr(0, 8'h03);
    chk("R2 pins both on", {6'd0, dtr_n, rts_n}, 8'd0);
    rd(0, d); chk("R2 readback", d, 8'h03);
    wr(0, 8'h01);
    chk("R2 dtr only", {6'd0, dtr_n, rts_n}, 8'd1);
    wr(0, 8'h08);
    chk("R10 irq_gate on", {7'd0, irq_gate}, 8'd1);
    wr(0, 8'h00);
    chk("R10 irq_gate off", {7'd0, irq_gate}, 8'd0);
  endtask

  task automatic t_status_write;
    logic [7:0] d;
    wr(1, 8'hFF);
    rd(1, d); chk("R12 status write ignored", d, 8'h00);
    rd(0, d); chk("R12 ctl untouched", d, 8'h00);
  endtask

  task automatic t_levels;
    logic [7:0] d;
    cts_n = 0;
    tick(); peek(d); chk("R3 not yet visible", d, 8'h00);
    tick(); peek(d); chk("R3 cts level after two clocks", d, 8'h10);
    tick(); peek(d); chk("R4 cts flag on fall", d, 8'h11);
    rd(1, d); chk("R7 read returns flags", d, 8'h11);
    peek(d); chk("R7 flags cleared", d, 8'h10);
    cts_n = 1; tick(3);
    peek(d); chk("R4 cts flag on rise", d, 8'h01);
    rd(1, d);
    dsr_n = 0; tick(3);
    peek(d); chk("R4 dsr flag", d, 8'h22);
    tick(4); peek(d); chk("R6 dsr flag sticky", d, 8'h22);
    rd(1, d);
    dsr_n = 1; tick(3); rd(1, d);
    chk("R4 dsr release", d, 8'h02);
  endtask

  task automatic t_ring;
    logic [7:0] d;
    ri_n = 0; tick(3);
    peek(d); chk("R5 ring start no flag", d, 8'h40);
    ri_n = 1; tick(3);
    peek(d); chk("R5 ring end flag", d, 8'h04);
    tick(5); peek(d); chk("R6 ring flag sticky", d, 8'h04);
    rd(1, d);
    peek(d); chk("R7 ring flag cleared", d, 8'h00);
  endtask

  task automatic t_read_race;
    logic [7:0] d;
    dcd_n = 0; tick(2);
    rd(1, d); chk("R7 read in change cycle", d, 8'h80);
    peek(d); chk("R7 change kept", d, 8'h88);
    rd(1, d); chk("R4 dcd flag", d, 8'h88);
    dcd_n = 1; tick(3); rd(1, d);
    chk("R4 dcd release", d, 8'h08);
  endtask

  task automatic t_msi;
    logic [7:0] d;
    wr(0, 8'h08);
    chk("R11 no flags no request", {7'd0, msi_req}, 8'd0);
    cts_n = 0; tick(3);
    chk("R11 request raised", {7'd0, msi_req}, 8'd1);
    rd(1, d);
    chk("R11 request cleared", {7'd0, msi_req}, 8'd0);
    wr(0, 8'h00);
    cts_n = 1; tick(3);
    chk("R11 disabled no request", {7'd0, msi_req}, 8'd0);
    rd(1, d);
  endtask

  task automatic t_loop;
    logic [7:0] d;
    wr(0, 8'h13);
    chk("R9 pins parked", {6'd0, dtr_n, rts_n}, 8'd3);
    peek(d); chk("R8 dtr->dsr rts->cts", d, 8'h30);
    tick(); peek(d); chk("R8 loop flags", d, 8'h33);
    rd(1, d);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0; tick(4);
    peek(d); chk("R8 pins ignored", d, 8'h30);
    wr(0, 8'h1C);
    chk("R10 gate off in loop", {7'd0, irq_gate}, 8'd0);
    tick(); peek(d); chk("R8 out bits->ri dcd", d, 8'hCB);
    chk("R11 request in loop", {7'd0, msi_req}, 8'd1);
    rd(1, d);
    wr(0, 8'h18); tick();
    peek(d); chk("R8 ring end in loop", d, 8'h84);
    rd(1, d);
    wr(0, 8'h00); tick();
    peek(d); chk("R8 leave loop", d, 8'hF3);
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; tick(3);
    rd(1, d); rd(1, d);
    chk("R6 idle after cleanup", d, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_control();
    t_status_write();
    t_levels();
    t_ring();
    t_read_race();
    t_msi();
    t_loop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule